// File: doc/BRIEF.md
# Dual-Channel Serial Result Sequencer

This block is the digital back end of a two-channel converter whose two inputs are held at the same instant. It takes the two parallel results that the conversion engine produces and sends them to a host over three wires. The host supplies an active-low chip select and a serial clock. A shutdown input is also provided. The block returns one serial data bit with a separate drive enable, for a tri-state pad outside the block, and a busy status flag.

Each frame is 32 serial clocks long and carries both results. Each result occupies a 16-bit slot: four zero bits come first, then the 12-bit value, most significant bit first. Channel A goes out before channel B. The block has no mode input. If the host pulses chip select high between frames, every frame starts on a chip-select falling edge. If the host holds chip select low, the block runs freely: after each frame there is one dead clock period, and then the next frame begins. Chip select high and shutdown high both clear the block at once, without waiting for a clock edge. A frame that is interrupted this way is lost.

The serial clock is the block's only clock. All state changes on its falling edge, so the host can sample the data on the rising edge.

Top module: `dual_result_serializer`

## Requirements
- R1: A frame is 32 bits. Positions 1–4 are 0, positions 5–16 carry `res_a` bits 11 down to 0, positions 17–20 are 0, and positions 21–32 carry `res_b` bits 11 down to 0. Position k is presented on `sdo` with `sdo_en` = 1 after the k-th serial-clock falling edge of the frame.
- R2: `sdo` changes only on serial-clock falling edges. The value present before a rising edge is still present after it.
- R3: While `cs_n` is 1, `sdo_en` and `status` are 0 at once, with no clock needed. After `cs_n` falls again, the next frame starts again from position 1.
- R4: When `cs_n` falls while `sd` is 0, `status` goes to 1 before any clock edge. `sdo_en` stays 0 until the first falling edge, which presents position 1.
- R5: `status` is 1 from the start of a frame through position 32. It is 0 in the clock period that follows position 32.
- R6: With `cs_n` held at 0, exactly one serial-clock period follows each frame with `sdo_en` = 0 and `status` = 0. The next falling edge starts a new frame at position 1 with `status` = 1.
- R7: Both results are captured on the falling edge that presents position 1. Changes to `res_a` or `res_b` after that edge have no effect on the frame being sent.
- R8: While `sd` is 1, `sdo_en` and `status` are 0 at once, with no clock needed, and any frame in progress is abandoned. After `sd` returns to 0 with `cs_n` at 0, `status` is 1 and the next falling edge starts a new frame at position 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its falling edge |
| cs_n | input | 1 | Active-low chip select; high clears the block without waiting for a clock |
| sd | input | 1 | Shutdown; high clears the block without waiting for a clock |
| res_a | input | 12 | Channel A result from the conversion engine |
| res_b | input | 12 | Channel B result from the conversion engine |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | Drive enable for the serial data pad (0 means high impedance) |
| status | output | 1 | High while a conversion frame is in progress |

## Verification
Two things can happen in the same cycle. The first is capturing new results while the previous frame ends. The second is a clear that arrives while bits are being shifted out. The bench changes both result inputs during the dead period, before the edge that loads them. It then changes them again partway through the frame. It checks that every bit matches the values present at the load edge. The bench also raises chip select, and separately shutdown, partway through a frame. It checks that the outputs drop at once, before the next clock. It then checks that the following frame starts again at position 1 with freshly captured results.

// File: rtl/sqr_pkg.sv
package sqr_pkg;

    // Registered control flags of the frame sequencer
    typedef struct packed {
        logic busy;
        logic drive;
    } seq_flags_t;

    // Width of one channel slot: zero padding plus the result field
    function automatic int slot_len(input int res_w, input int pad_w);
        return res_w + pad_w;
    endfunction

endpackage

// File: rtl/sqr_frame_pack.sv
module sqr_frame_pack #(
    parameter  int RES_W   = 12,
    parameter  int PAD_W   = 4,
    parameter  int CH_N    = 2,
    localparam int SLOT_W  = RES_W + PAD_W,
    localparam int FRAME_W = SLOT_W * CH_N
) (
    input  logic [CH_N-1:0][RES_W-1:0] res,
    output logic [FRAME_W-1:0]         frame
);

    // Channel 0 occupies the most significant slot and goes out first
    for (genvar ch = 0; ch < CH_N; ch++) begin : g_slot
        assign frame[FRAME_W-1-ch*SLOT_W -: SLOT_W] = {{PAD_W{1'b0}}, res[ch]};
    end

endmodule

// File: rtl/sqr_seq_ctrl.sv
module sqr_seq_ctrl import sqr_pkg::*; #(
    parameter  int FRAME_W = 32,
    localparam int CW      = $clog2(FRAME_W + 2),
    localparam int DEAD    = FRAME_W + 1
) (
    input  logic          sclk,
    input  logic          clr,
    output logic          load,
    output logic [CW-1:0] pos,
    output logic          busy,
    output logic          drive
);

    // cnt: 0 = armed, 1..FRAME_W = bit position shown, DEAD = idle clock
    typedef struct packed {
        logic [CW-1:0] cnt;
        seq_flags_t    fl;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (st_q.cnt == '0 || st_q.cnt == CW'(DEAD)) begin
            load          = 1'b1;
            st_d.cnt      = CW'(1);
            st_d.fl.busy  = 1'b1;
            st_d.fl.drive = 1'b1;
        end else if (st_q.cnt == CW'(FRAME_W)) begin
            st_d.cnt      = CW'(DEAD);
            st_d.fl.busy  = 1'b0;
            st_d.fl.drive = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(negedge sclk or posedge clr) begin
        if (clr) begin
            st_q <= '{cnt: '0, fl: '{busy: 1'b1, drive: 1'b0}};
        end else begin
            st_q <= st_d;
        end
    end

    assign pos   = st_q.cnt;
    assign busy  = st_q.fl.busy;
    assign drive = st_q.fl.drive;

    // R5: the pad is never driven outside a conversion
    assert_drive_in_busy_R5: assert property (@(negedge sclk) disable iff (clr)
        st_q.fl.drive |-> st_q.fl.busy);

    // R5: the edge after the last bit drops both busy and drive
    assert_busy_end_R5: assert property (@(negedge sclk) disable iff (clr)
        (st_q.cnt == CW'(FRAME_W)) |=> (!st_q.fl.busy && !st_q.fl.drive));

    // R6: a single idle clock is followed directly by a new frame
    assert_one_dead_R6: assert property (@(negedge sclk) disable iff (clr)
        (st_q.cnt == CW'(DEAD)) |=> (st_q.cnt == CW'(1) && st_q.fl.busy));

endmodule

// File: rtl/sqr_shift.sv
module sqr_shift #(
    parameter int FRAME_W = 32
) (
    input  logic               sclk,
    input  logic               clr,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               bit_out
);

    logic [FRAME_W-1:0] sh_d, sh_q;

    always_comb begin
        if (load) begin
            sh_d = frame;
        end else begin
            sh_d = {sh_q[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(negedge sclk or posedge clr) begin
        if (clr) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign bit_out = sh_q[FRAME_W-1];

endmodule

// File: rtl/dual_result_serializer.sv
module dual_result_serializer import sqr_pkg::*; #(
    parameter  int RES_W   = 12,
    parameter  int PAD_W   = 4,
    localparam int SLOT_W  = slot_len(RES_W, PAD_W),
    localparam int FRAME_W = 2 * SLOT_W,
    localparam int CW      = $clog2(FRAME_W + 2)
) (
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sd,
    input  logic [RES_W-1:0] res_a,
    input  logic [RES_W-1:0] res_b,
    output logic             sdo,
    output logic             sdo_en,
    output logic             status
);

    logic                  clr;
    logic                  load;
    logic [CW-1:0]         pos;
    logic                  busy;
    logic                  drive;
    logic                  sh_bit;
    logic [1:0][RES_W-1:0] res_pk;
    logic [FRAME_W-1:0]    frame;

    // Deselect and shutdown both clear the sequencer without a clock
    assign clr = cs_n | sd;

    assign res_pk[0] = res_a;
    assign res_pk[1] = res_b;

    sqr_frame_pack #(.RES_W(RES_W), .PAD_W(PAD_W), .CH_N(2)) u_pack (
        .res   (res_pk),
        .frame (frame)
    );

    sqr_seq_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
        .sclk  (sclk),
        .clr   (clr),
        .load  (load),
        .pos   (pos),
        .busy  (busy),
        .drive (drive)
    );

    sqr_shift #(.FRAME_W(FRAME_W)) u_shift (
        .sclk    (sclk),
        .clr     (clr),
        .load    (load),
        .frame   (frame),
        .bit_out (sh_bit)
    );

    assign sdo    = sh_bit & drive;
    assign sdo_en = drive;
    assign status = busy & ~clr;

    logic pad_zone;
    assign pad_zone = (pos >= CW'(1) && pos <= CW'(PAD_W)) ||
                      (pos > CW'(SLOT_W) && pos <= CW'(SLOT_W + PAD_W));

    // R1: padding positions of both slots carry zero
    assert_pad_zero_R1: assert property (@(negedge sclk) disable iff (clr)
        pad_zone |-> !sdo);

endmodule

// File: tb/tb_dual_result_serializer.sv
module tb_dual_result_serializer;

    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sd   = 1'b0;
    logic [11:0] ra   = '0;
    logic [11:0] rb   = '0;
    logic        sdo, sdo_en, status;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #4 sclk = ~sclk;   // 125 MHz

    dual_result_serializer dut (
        .sclk   (sclk),
        .cs_n   (cs_n),
        .sd     (sd),
        .res_a  (ra),
        .res_b  (rb),
        .sdo    (sdo),
        .sdo_en (sdo_en),
        .status (status)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input logic [11:0] a, input logic [11:0] b);
        return {4'b0000, a, 4'b0000, b};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Expects the next nbits falling edges to present frame positions 1..nbits
    task automatic run_bits(input logic [11:0] a, input logic [11:0] b, input int nbits);
        logic [31:0] f;
        logic        s1;
        f = exp_frame(a, b);
        for (int i = 0; i < nbits; i++) begin
            @(negedge sclk);
            #3;
            s1 = sdo;
            #2;
            chk("R2", "bit stable across rising edge", {31'd0, sdo}, {31'd0, s1});
            chk("R1", $sformatf("bit %0d", i + 1), {31'd0, sdo}, {31'd0, f[31-i]});
            chk("R1", "drive enable in frame", {31'd0, sdo_en}, 32'd1);
            chk("R5", "status in frame", {31'd0, status}, 32'd1);
            if (i == 5) begin
                // R7: disturb the inputs after capture
                ra = 12'($urandom);
                rb = 12'($urandom);
            end
        end
    endtask

    task automatic dead_clock();
        @(negedge sclk);
        #3;
        chk("R6", "drive off in dead clock", {31'd0, sdo_en}, 32'd0);
        chk("R5", "status low in dead clock", {31'd0, status}, 32'd0);
    endtask

    initial begin
        logic [11:0] va, vb;
        void'($urandom(32'd2024));

        // R3: deselected reset state
        repeat (3) @(negedge sclk);
        #3;
        chk("R3", "drive while deselected", {31'd0, sdo_en}, 32'd0);
        chk("R3", "status while deselected", {31'd0, status}, 32'd0);

        // R4: slave-mode start
        va = 12'hFFF; vb = 12'h000;
        ra = va; rb = vb;
        @(negedge sclk);
        #1 cs_n = 1'b0;
        #1;
        chk("R4", "status after select", {31'd0, status}, 32'd1);
        chk("R4", "drive before first edge", {31'd0, sdo_en}, 32'd0);
        run_bits(va, vb, 32);

        // R6 / R7: free-running frames, corners then random
        for (int k = 0; k < 24; k++) begin
            dead_clock();
            case (k)
                0: begin va = 12'h000; vb = 12'hFFF; end
                1: begin va = 12'h800; vb = 12'h001; end
                2: begin va = 12'hAAA; vb = 12'h555; end
                default: begin va = 12'($urandom); vb = 12'($urandom); end
            endcase
            ra = va; rb = vb;
            run_bits(va, vb, 32);
        end

        // R3: abort by deselect mid-frame
        dead_clock();
        va = 12'h3C5; vb = 12'hA96;
        ra = va; rb = vb;
        run_bits(va, vb, 10);
        #1 cs_n = 1'b1;
        #1;
        chk("R3", "drive drops on deselect", {31'd0, sdo_en}, 32'd0);
        chk("R3", "status drops on deselect", {31'd0, status}, 32'd0);
        @(negedge sclk);
        #3;
        chk("R3", "drive stays off deselected", {31'd0, sdo_en}, 32'd0);
        va = 12'h5A1; vb = 12'h0F0;
        ra = va; rb = vb;
        #1 cs_n = 1'b0;
        run_bits(va, vb, 32);   // R3: restarts at position 1

        // R8: shutdown mid-frame
        dead_clock();
        va = 12'h7E3; vb = 12'h19C;
        ra = va; rb = vb;
        run_bits(va, vb, 7);
        #1 sd = 1'b1;
        #1;
        chk("R8", "drive drops on shutdown", {31'd0, sdo_en}, 32'd0);
        chk("R8", "status drops on shutdown", {31'd0, status}, 32'd0);
        repeat (2) begin
            @(negedge sclk);
            #3;
            chk("R8", "status held low in shutdown", {31'd0, status}, 32'd0);
            chk("R8", "drive held off in shutdown", {31'd0, sdo_en}, 32'd0);
        end
        va = 12'hC3B; vb = 12'h4D2;
        ra = va; rb = vb;
        sd = 1'b0;
        #1;
        chk("R8", "status after wake", {31'd0, status}, 32'd1);
        chk("R8", "drive before restart edge", {31'd0, sdo_en}, 32'd0);
        run_bits(va, vb, 32);   // R8: fresh frame from position 1
        dead_clock();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule